// File: doc/BRIEF.md
# Prioritized Video-Memory Transfer Queue

This block is a timing and occupancy model of the write path into video memory. It does not move any data. Each request names a number of words and carries three flags: byte-wide access, background DMA (fill or copy) and foreground DMA. Requests wait in a small circular queue. The entry at the head is worn down by one transfer unit on each access-slot strobe. From the number of units still pending, the block derives the CPU write stall, the CPU read stall, FULL and EMPTY status bits, a DMA busy flag and a one-cycle DMA-done pulse.

A background DMA is held back in favour of the CPU. It always stays behind CPU traffic that arrives later, and its units are left out of the occupancy level. The level, and so the stalls and status bits, reflects only CPU and foreground DMA work. A queue that goes from empty to non-empty waits a few slots before its first unit is served. This models the start-up latency of the real pipeline.

Top module: `vram_xfer_queue`

## Requirements
- R1: After reset, level is 0, fifo_empty is 1, and fifo_full, wr_stall, rd_stall, dma_busy and dma_done are all 0.
- R2: An accepted push without the background flag adds its word count to level, visible one cycle later. fifo_empty is 1 exactly when level is 0. fifo_full is 1 exactly when level is 4 or more.
- R3: When a push lands in an empty queue, the first LAT_SLOTS (default 4) slot strobes transfer nothing. The strobe after them serves the first unit.
- R4: A word entry frees one word of level per served strobe. A byte entry needs two served strobes per word of level, so its slot budget is the count shifted left by the byte flag.
- R5: wr_stall is 1 exactly while level is above STALL_LVL (default 4).
- R6: rd_req raises rd_stall whenever level after that cycle is non-zero. rd_stall then stays high until level reaches 0.
- R7: A background DMA push leaves level unchanged and sets dma_busy.
- R8: A push that arrives while the last queue entry is background DMA is placed ahead of it. If that DMA entry was the only one and was already being served, its remaining count is kept and it resumes after the new entry drains.
- R9: When a background DMA entry serves its last slot, dma_done is high for exactly one cycle and dma_busy falls.
- R10: A foreground DMA ends, with a one-cycle dma_done pulse, once level is at most STALL_LVL, the last entry is not background DMA and fill_wait is low.
- R11: A push with a word count of 0, or a push made while all DEPTH (default 8) entries are in use, changes nothing.
- R12: A push and a served strobe in the same cycle both take effect. The serve is applied first, then the push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Request to queue a transfer this cycle |
| push_count | input | CNT_W (8) | Words in the request |
| push_byte | input | 1 | Request uses byte-wide slots (two per word) |
| push_bgdma | input | 1 | Request is a background DMA fill or copy |
| push_fgdma | input | 1 | Request is a foreground DMA |
| slot_strobe | input | 1 | One access slot is available this cycle |
| rd_req | input | 1 | CPU read wants the bus |
| fill_wait | input | 1 | A fill is still waiting for its data word |
| wr_stall | output | 1 | CPU write must wait |
| rd_stall | output | 1 | CPU read must wait |
| fifo_full | output | 1 | FULL status bit |
| fifo_empty | output | 1 | EMPTY status bit |
| dma_busy | output | 1 | A DMA is in progress |
| dma_done | output | 1 | One-cycle pulse when a DMA ends |
| level | output | TOT_W (12) | Pending units excluding background DMA |

## Verification
The assertions watch these on every cycle: level holds in a cycle with no strobe and no push, level never rises without a push and falls by at most one per cycle, rd_stall holds until level is zero, a background push leaves level alone, and the queue length never passes its depth. They also check that dma_done is a single-cycle pulse with dma_busy low. Which unit a given strobe serves can only be shown by the bench scenarios. That covers the start-up latency, the two-slot byte pacing, the point where a reordered background DMA completes, and the foreground DMA release that waits on fill_wait. The bench sweeps counts and access widths and predicts level after every strobe.

// File: rtl/vxq_pkg.sv
`timescale 1ns/1ps
package vxq_pkg;
  localparam int unsigned CNT_W = 8;

  typedef struct packed {
    logic [CNT_W-1:0] words;
    logic             is_byte;
    logic             bg;
    logic             fg;
  } xfer_t;

  // slot budget for a request: byte access takes two slots per word
  function automatic logic [CNT_W:0] slots_of(input logic [CNT_W-1:0] w, input logic b);
    return b ? {w, 1'b0} : {1'b0, w};
  endfunction

  // words still owed by an entry whose slot budget is s
  function automatic logic [CNT_W-1:0] words_left(input logic [CNT_W:0] s, input logic b);
    return b ? s[CNT_W:1] : s[CNT_W-1:0];
  endfunction

  // does serving one slot with budget r (before the slot) retire a whole word
  function automatic logic unit_done(input logic [CNT_W:0] r, input logic b);
    return b ? r[0] : 1'b1;
  endfunction
endpackage

// File: rtl/vxq_launch_delay.sv
`timescale 1ns/1ps
module vxq_launch_delay #(
  parameter int LAT_SLOTS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic slot_strobe,
  input  logic active,
  output logic ready
);
  localparam int LAT_W = $clog2(LAT_SLOTS + 2);
  localparam logic [LAT_W-1:0] LAT_V = LAT_W'(LAT_SLOTS);

  logic [LAT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (launch) begin
      wait_q <= LAT_V;
    end else if (slot_strobe && active && wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign ready = (wait_q == '0);
endmodule

// File: rtl/vxq_dma_track.sv
`timescale 1ns/1ps
module vxq_dma_track #(
  parameter int TOT_W     = 12,
  parameter int STALL_LVL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bg_finish,
  input  logic [TOT_W-1:0] tot_next,
  input  logic             tail_bg_next,
  input  logic             fill_wait,
  output logic             busy,
  output logic             done
);
  localparam logic [TOT_W-1:0] LVL_V = TOT_W'(STALL_LVL);

  logic busy_q, done_q, fg_release, clr;

  assign fg_release = busy_q && (tot_next <= LVL_V) && !tail_bg_next && !fill_wait;
  assign clr        = bg_finish || fg_release;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= start ? 1'b1 : (clr ? 1'b0 : busy_q);
      done_q <= busy_q && clr && !start;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/vxq_flags.sv
`timescale 1ns/1ps
module vxq_flags #(
  parameter int TOT_W     = 12,
  parameter int STALL_LVL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOT_W-1:0] tot_q,
  input  logic [TOT_W-1:0] tot_next,
  input  logic             rd_req,
  output logic             wr_stall,
  output logic             rd_stall,
  output logic             full,
  output logic             empty
);
  localparam logic [TOT_W-1:0] LVL_V = TOT_W'(STALL_LVL);

  logic rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= (rd_req || rd_q) && (tot_next != '0);
  end

  assign rd_stall = rd_q;
  assign wr_stall = (tot_q > LVL_V);
  assign full     = (tot_q >= LVL_V);
  assign empty    = (tot_q == '0);
endmodule

// File: rtl/vram_xfer_queue.sv
`timescale 1ns/1ps
module vram_xfer_queue
  import vxq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int STALL_LVL = 4,
  parameter int LAT_SLOTS = 4,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int LEN_W    = $clog2(DEPTH + 1),
  localparam int TOT_W    = CNT_W + IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [CNT_W-1:0] push_count,
  input  logic             push_byte,
  input  logic             push_bgdma,
  input  logic             push_fgdma,
  input  logic             slot_strobe,
  input  logic             rd_req,
  input  logic             fill_wait,
  output logic             wr_stall,
  output logic             rd_stall,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic             dma_busy,
  output logic             dma_done,
  output logic [TOT_W-1:0] level
);
  localparam logic [LEN_W-1:0] DEPTH_V = LEN_W'(DEPTH);

  // architectural state
  xfer_t            q_mem [DEPTH];
  logic [IDX_W-1:0] head_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W:0]   rem_q;
  logic [TOT_W-1:0] total_q;

  // next state
  xfer_t            mem_n [DEPTH];
  logic [IDX_W-1:0] head_mid;
  logic [LEN_W-1:0] len_mid, len_n;
  logic [CNT_W:0]   rem_mid, rem_n;
  logic [TOT_W-1:0] tot_mid, tot_n;

  // named internal events
  logic   lat_ready, serve_fire, pop_fire, bg_finish;
  logic   push_ok, launch, insert_ahead, tail_bg_n;
  logic [IDX_W-1:0] tail_idx, tail_n_idx;
  xfer_t  head_e, new_e, moved_e;

  assign head_e     = q_mem[head_q];
  assign serve_fire = slot_strobe && (len_q != '0) && lat_ready;
  assign pop_fire   = serve_fire && (rem_q == {{CNT_W{1'b0}}, 1'b1});
  assign bg_finish  = pop_fire && head_e.bg;

  assign new_e.words   = push_count;
  assign new_e.is_byte = push_byte;
  assign new_e.bg      = push_bgdma;
  assign new_e.fg      = push_fgdma;

  always_comb begin
    mem_n        = q_mem;
    head_mid     = head_q;
    len_mid      = len_q;
    rem_mid      = rem_q;
    tot_mid      = total_q;
    push_ok      = 1'b0;
    launch       = 1'b0;
    insert_ahead = 1'b0;
    moved_e      = '0;

    // step 1: the slot strobe wears down the head entry
    if (serve_fire) begin
      rem_mid = rem_q - 1'b1;
      if (!head_e.bg && unit_done(rem_q, head_e.is_byte))
        tot_mid = total_q - 1'b1;
      if (pop_fire) begin
        head_mid = head_q + 1'b1;
        len_mid  = len_q - 1'b1;
        if (len_mid != '0)
          rem_mid = slots_of(q_mem[head_mid].words, q_mem[head_mid].is_byte);
      end
    end

    tail_idx = IDX_W'(head_mid + IDX_W'(len_mid) - IDX_W'(1));
    len_n    = len_mid;
    rem_n    = rem_mid;
    tot_n    = tot_mid;

    // step 2: a new request joins the queue
    push_ok = push_valid && (push_count != '0) && (len_mid != DEPTH_V);
    if (push_ok) begin
      if (len_mid == '0) begin
        mem_n[head_mid] = new_e;
        rem_n           = slots_of(push_count, push_byte);
        launch          = 1'b1;
      end else if (q_mem[tail_idx].bg) begin
        // the background DMA yields its place and moves one slot back
        insert_ahead = 1'b1;
        moved_e      = q_mem[tail_idx];
        if (len_mid == LEN_W'(1)) begin
          moved_e.words = words_left(rem_mid, moved_e.is_byte);
          rem_n         = slots_of(push_count, push_byte);
        end
        mem_n[IDX_W'(tail_idx + 1'b1)] = moved_e;
        mem_n[tail_idx]                = new_e;
      end else begin
        mem_n[IDX_W'(tail_idx + 1'b1)] = new_e;
      end
      len_n = len_mid + 1'b1;
      if (!push_bgdma) tot_n = tot_mid + TOT_W'(push_count);
    end

    if (len_n == '0) tot_n = '0;

    tail_n_idx = IDX_W'(head_mid + IDX_W'(len_n) - IDX_W'(1));
    tail_bg_n  = (len_n != '0) && mem_n[tail_n_idx].bg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      total_q <= '0;
      for (int i = 0; i < DEPTH; i++) q_mem[i] <= '0;
    end else begin
      head_q  <= head_mid;
      len_q   <= len_n;
      rem_q   <= rem_n;
      total_q <= tot_n;
      q_mem   <= mem_n;
    end
  end

  vxq_launch_delay #(.LAT_SLOTS(LAT_SLOTS)) u_delay (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .slot_strobe (slot_strobe),
    .active      (len_q != '0),
    .ready       (lat_ready)
  );

  vxq_dma_track #(.TOT_W(TOT_W), .STALL_LVL(STALL_LVL)) u_dma (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (push_ok && (push_bgdma || push_fgdma)),
    .bg_finish    (bg_finish),
    .tot_next     (tot_n),
    .tail_bg_next (tail_bg_n),
    .fill_wait    (fill_wait),
    .busy         (dma_busy),
    .done         (dma_done)
  );

  vxq_flags #(.TOT_W(TOT_W), .STALL_LVL(STALL_LVL)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .tot_q    (total_q),
    .tot_next (tot_n),
    .rd_req   (rd_req),
    .wr_stall (wr_stall),
    .rd_stall (rd_stall),
    .full     (fifo_full),
    .empty    (fifo_empty)
  );

  assign level = total_q;
endmodule

// File: rtl/vxq_checker.sv
`timescale 1ns/1ps
module vxq_checker #(
  parameter int DEPTH = 8,
  parameter int TOT_W = 12,
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_strobe,
  input logic             push_valid,
  input logic             push_bgdma,
  input logic [TOT_W-1:0] level,
  input logic             rd_stall,
  input logic             dma_busy,
  input logic             dma_done,
  input logic             pop_fire,
  input logic [LEN_W-1:0] q_len
);
  localparam logic [LEN_W-1:0] DEPTH_V = LEN_W'(DEPTH);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_strobe && !push_valid) |=> $stable(level));

  // R4: without a push, level can only fall, and by at most one unit per cycle
  assert_drain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid |=> (level <= $past(level)) && (($past(level) - level) <= 1));

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |=> (rd_stall || level == '0));

  assert_bg_uncounted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_bgdma && !slot_strobe) |=> $stable(level));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> !dma_done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> !dma_busy);

  assert_full_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q_len == DEPTH_V && !pop_fire) |=> (q_len == DEPTH_V));

  always_comb begin
    if (rst_n) assert_len_cap_R11: assert (q_len <= DEPTH_V);
  end
endmodule

bind vram_xfer_queue vxq_checker #(.DEPTH(DEPTH), .TOT_W(TOT_W), .LEN_W(LEN_W)) u_vxq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_strobe (slot_strobe),
  .push_valid  (push_valid),
  .push_bgdma  (push_bgdma),
  .level       (level),
  .rd_stall    (rd_stall),
  .dma_busy    (dma_busy),
  .dma_done    (dma_done),
  .pop_fire    (pop_fire),
  .q_len       (len_q)
);

// File: tb/vram_xfer_queue_bench.sv
`timescale 1ns/1ps
module vram_xfer_queue_bench;
  localparam int LAT = 4;
  localparam int LVL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [7:0]  push_count = '0;
  logic        push_byte = 1'b0, push_bgdma = 1'b0, push_fgdma = 1'b0;
  logic        slot_strobe = 1'b0, rd_req = 1'b0, fill_wait = 1'b0;
  logic        wr_stall, rd_stall, fifo_full, fifo_empty, dma_busy, dma_done;
  logic [11:0] level;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vram_xfer_queue u_vram_xfer_queue (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_count(push_count),
    .push_byte(push_byte), .push_bgdma(push_bgdma), .push_fgdma(push_fgdma),
    .slot_strobe(slot_strobe), .rd_req(rd_req), .fill_wait(fill_wait),
    .wr_stall(wr_stall), .rd_stall(rd_stall), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .dma_busy(dma_busy), .dma_done(dma_done), .level(level)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_level(input string req, input int exp);
    chk({req, " level"}, int'(level), exp);
    chk("R2 empty", int'(fifo_empty), int'(exp == 0));
    chk("R2 full", int'(fifo_full), int'(exp >= LVL));
    chk("R5 wr_stall", int'(wr_stall), int'(exp > LVL));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    push_valid = 0; slot_strobe = 0; rd_req = 0; fill_wait = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // cycle with optional push and strobe; sampled one negedge later
  task automatic step(input bit p, input int cnt, input bit b, input bit bg, input bit fg, input bit s);
    push_valid = p; push_count = 8'(cnt); push_byte = b; push_bgdma = bg; push_fgdma = fg;
    slot_strobe = s;
    @(negedge clk);
    push_valid = 0; slot_strobe = 0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1 level", int'(level), 0);
    chk("R1 empty", int'(fifo_empty), 1);
    chk("R1 full", int'(fifo_full), 0);
    chk("R1 wr_stall", int'(wr_stall), 0);
    chk("R1 rd_stall", int'(rd_stall), 0);
    chk("R1 dma_busy", int'(dma_busy), 0);
    chk("R1 dma_done", int'(dma_done), 0);

    // R3/R4 sweep: count x width, level predicted after every strobe
    for (int b = 0; b < 2; b++) begin
      for (int c = 1; c <= 6; c++) begin
        do_reset();
        step(1, c, b[0], 0, 0, 0);
        chk_level("R2 push", c);
        for (int j = 1; j <= LAT + 2 * c + 1; j++) begin
          int k, e;
          step(0, 0, 0, 0, 0, 1);
          k = (j > LAT) ? j - LAT : 0;
          e = (b == 1) ? c - k / 2 : c - k;
          if (e < 0) e = 0;
          chk_level(j <= LAT ? "R3 latency" : (b == 1 ? "R4 byte" : "R4 word"), e);
        end
      end
    end

    // R11: zero-count push ignored
    do_reset();
    step(1, 0, 0, 0, 0, 0);
    chk_level("R11 zero", 0);

    // R11: ninth push ignored when eight entries are in use
    do_reset();
    for (int i = 0; i < 8; i++) step(1, 1, 0, 0, 0, 0);
    chk_level("R11 fill", 8);
    step(1, 5, 0, 0, 0, 0);
    chk_level("R11 overflow", 8);
    for (int j = 1; j <= LAT + 8; j++) begin
      step(0, 0, 0, 0, 0, 1);
      chk_level("R11 drain", (j <= LAT) ? 8 : 8 - (j - LAT));
    end

    // R12: simultaneous push and served strobe
    do_reset();
    step(1, 2, 0, 0, 0, 0);
    for (int j = 0; j < LAT; j++) step(0, 0, 0, 0, 0, 1);
    chk_level("R12 pre", 2);
    step(1, 3, 0, 0, 0, 1);
    chk_level("R12 both", 4);

    // R6: read stall held until level reaches 0
    do_reset();
    rd_req = 1; step(0, 0, 0, 0, 0, 0); rd_req = 0;
    chk("R6 idle read", int'(rd_stall), 0);
    step(1, 3, 0, 0, 0, 0);
    rd_req = 1; step(0, 0, 0, 0, 0, 0); rd_req = 0;
    chk("R6 set", int'(rd_stall), 1);
    for (int j = 1; j <= LAT + 3; j++) begin
      step(0, 0, 0, 0, 0, 1);
      chk("R6 hold", int'(rd_stall), int'(j < LAT + 3));
    end

    // R7/R8/R9: background DMA served once, then overtaken by a CPU write
    begin
      int bgc = 3, cpu = 2, served = 1, remain;
      do_reset();
      step(1, bgc, 0, 1, 0, 0);
      chk_level("R7 bg push", 0);
      chk("R7 busy", int'(dma_busy), 1);
      for (int j = 0; j < LAT + served; j++) step(0, 0, 0, 0, 0, 1);
      chk("R9 no early done", int'(dma_done), 0);
      step(1, cpu, 0, 0, 0, 0);
      chk_level("R8 cpu ahead", cpu);
      remain = cpu + bgc - served;
      for (int j = 1; j <= remain; j++) begin
        step(0, 0, 0, 0, 0, 1);
        chk("R8 level", int'(level), (j < cpu) ? cpu - j : 0);
        chk("R9 done timing", int'(dma_done), int'(j == remain));
      end
      chk("R9 busy cleared", int'(dma_busy), 0);
      step(0, 0, 0, 0, 0, 0);
      chk("R9 single pulse", int'(dma_done), 0);
    end

    // R10: foreground DMA ends once level reaches the stall level
    do_reset();
    step(1, 6, 0, 0, 1, 0);
    chk("R10 busy", int'(dma_busy), 1);
    for (int j = 1; j <= LAT + 2; j++) begin
      step(0, 0, 0, 0, 0, 1);
      chk("R10 done", int'(dma_done), int'(j == LAT + 2));
      chk("R10 busy", int'(dma_busy), int'(j < LAT + 2));
    end

    // R10: a pending fill holds the foreground DMA open
    do_reset();
    fill_wait = 1;
    step(1, 6, 0, 0, 1, 0);
    for (int j = 1; j <= LAT + 6; j++) step(0, 0, 0, 0, 0, 1);
    chk("R10 fill level", int'(level), 0);
    chk("R10 fill busy", int'(dma_busy), 1);
    fill_wait = 0;
    step(0, 0, 0, 0, 0, 0);
    chk("R10 fill done", int'(dma_done), 1);
    chk("R10 fill busy off", int'(dma_busy), 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule